// File: doc/BRIEF.md
# Transmit Packet Framer with Sequence Stamp and CRC Trailer

This block sits between user logic and a link layer. Packets arrive on a 32-bit valid/ready stream, framed by start and end markers. The last beat of each packet carries a count of unused trailing bytes. Each incoming packet has a 6-bit sequence slot at its very front, left empty by the sender, and it has no checksum and no alignment fill. The block makes no judgement about whether the packet is well formed.

On the way out, the block does three things. It writes its own rolling sequence number into the front slot. It computes a 16-bit CRC over the packet with the slot counted as zeros, and places the CRC straight after the last payload byte. It then fills with zero bytes up to the next 32-bit boundary, so every output packet ends on a full word. The output uses the same valid/ready/start/end handshake. A stalled output throttles the input through a one-word holding stage. If the sender lets valid drop in the middle of a packet, the block raises a one-cycle error flag.

Top module: `txf_framer`

## Requirements
- R1: An input beat moves only on a cycle where `in_valid` and `in_ready` are both high, and `in_ready` may rise in the same cycle it is used. An output word that is offered (`out_valid` high) but not taken (`out_ready` low) stays unchanged in `out_data`, `out_sop` and `out_eop` on the next cycle.
- R2: In the first word of every output packet, bits [31:26] hold the sequence number. After reset the first packet carries 0. The number then rises by one, modulo 64, for each packet whose final word has been taken.
- R3: Bytes travel in big-endian order: byte k of a beat sits in bits [31-8k -: 8]. Every payload bit other than the sequence slot leaves the block unchanged and in its original order, with no packet lost, merged or reordered.
- R4: The CRC uses polynomial 0x1021, is processed MSB first, starts from 0xFFFF and has no final inversion. It covers all payload bytes, with bits [31:26] of the first beat taken as zero. The high CRC byte is placed directly after the last payload byte, followed by the low CRC byte.
- R5: After the CRC, zero bytes are added up to a 32-bit boundary, so the output end word is always full. When the last input beat has 0 or 1 unused bytes, the CRC spills into one extra output word.
- R6: `in_empty` gives the number of unused low-order bytes of the end beat and is ignored on any other beat. The contents of unused byte lanes never reach the output.
- R7: `proto_err` is high for exactly the one cycle that follows each cycle in which a packet has been started on the input (start beat taken, end beat not yet taken) and `in_valid` is low.
- R8: During and right after reset, `out_valid` and `proto_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can take an input beat this cycle |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_empty | input | 2 | Unused low-order bytes on the last beat |
| in_data | input | 32 | Input beat, byte 0 in bits [31:24] |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Link layer takes the output word |
| out_sop | output | 1 | First word of an output packet |
| out_eop | output | 1 | Last word of an output packet (always full) |
| out_data | output | 32 | Output word |
| proto_err | output | 1 | One-cycle pulse after a valid gap inside a packet |

## Verification
Two events can fall in the same cycle. One is the hand-off of a short end word into the extra CRC word. The other is the capture of the next packet's start beat into the holding stage. That capture also restarts the CRC and precedes the sequence step. The bench provokes the overlap with back-to-back packets of every trailing-byte count under random output stalls. It fills unused byte lanes and the empty count of middle beats with random values. Every output word is compared with a stream that bench functions build from the byte list of each packet, its CRC and its expected sequence number.

// File: rtl/txf_pkg.sv
package txf_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WORD_BYTES = WORD_W / 8;
    localparam int unsigned EMPTY_W    = $clog2(WORD_BYTES);
    localparam int unsigned CNT_W      = EMPTY_W + 1;
    localparam int unsigned CRC_W      = 16;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [EMPTY_W-1:0] empty_t;
    typedef logic [CRC_W-1:0]   crc_t;

    // one byte through the serial CRC register, MSB first
    function automatic crc_t crc_byte(input crc_t c_in, input logic [7:0] b, input crc_t poly);
        crc_t c;
        logic fb;
        c = c_in;
        for (int i = 7; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ b[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction
endpackage

// File: rtl/txf_crc_word.sv
module txf_crc_word
    import txf_pkg::*;
#(
    parameter crc_t POLY = 16'h1021
) (
    input  crc_t             crc_i,
    input  word_t            data_i,
    input  logic [CNT_W-1:0] nbytes_i,
    output crc_t             crc_o
);
    always_comb begin
        crc_t c;
        c = crc_i;
        for (int k = 0; k < int'(WORD_BYTES); k++) begin
            if (k < int'(nbytes_i)) c = crc_byte(c, data_i[WORD_W-1-8*k -: 8], POLY);
        end
        crc_o = c;
    end
endmodule

// File: rtl/txf_seq_ctr.sv
module txf_seq_ctr #(
    parameter int unsigned SEQ_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_i,
    output logic [SEQ_W-1:0] seq_o
);
    logic [SEQ_W-1:0] seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (adv_i) seq_d = seq_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign seq_o = seq_q;
endmodule

// File: rtl/txf_tail_merge.sv
module txf_tail_merge
    import txf_pkg::*;
#(
    parameter int unsigned SEQ_W = 6
) (
    input  word_t            word_i,
    input  logic             sop_i,
    input  logic             eop_i,
    input  empty_t           empty_i,
    input  logic [SEQ_W-1:0] seq_i,
    input  crc_t             crc_i,
    output word_t            main_o,
    output logic             main_last_o,
    output word_t            tail_o
);
    word_t base;

    always_comb begin
        base = word_i;
        if (sop_i) base[WORD_W-1 -: SEQ_W] = seq_i;
    end

    always_comb begin
        main_o      = base;
        tail_o      = '0;
        main_last_o = eop_i && (empty_i >= 2'd2);
        if (eop_i) begin
            case (empty_i)
                2'd0: tail_o = {crc_i, 16'h0000};
                2'd1: begin
                    main_o = {base[31:8], crc_i[15:8]};
                    tail_o = {crc_i[7:0], 24'h000000};
                end
                2'd2: main_o = {base[31:16], crc_i};
                default: main_o = {base[31:24], crc_i, 8'h00};
            endcase
        end
    end
endmodule

// File: rtl/txf_framer.sv
module txf_framer
    import txf_pkg::*;
#(
    parameter int unsigned SEQ_W    = 6,
    parameter crc_t        CRC_POLY = 16'h1021,
    parameter crc_t        CRC_INIT = 16'hFFFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic        in_sop,
    input  logic        in_eop,
    input  logic [1:0]  in_empty,
    input  logic [31:0] in_data,
    output logic        out_valid,
    input  logic        out_ready,
    output logic        out_sop,
    output logic        out_eop,
    output logic [31:0] out_data,
    output logic        proto_err
);
    typedef struct packed {
        logic   hold_vld;
        word_t  hold_data;
        logic   hold_sop;
        logic   hold_eop;
        empty_t hold_empty;
        logic   tail_vld;
        word_t  tail_data;
        crc_t   crc;
        logic   in_pkt;
        logic   err;
    } st_t;

    st_t st_d, st_q;

    logic             hold_fire, tail_fire, in_fire, seq_adv;
    logic [SEQ_W-1:0] seq;
    word_t            main_word, tail_word, crc_data;
    logic             main_last;
    crc_t             crc_base, crc_next;
    logic [CNT_W-1:0] crc_nbytes;

    txf_seq_ctr #(.SEQ_W(SEQ_W)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .adv_i (seq_adv),
        .seq_o (seq)
    );

    txf_tail_merge #(.SEQ_W(SEQ_W)) merge_i (
        .word_i      (st_q.hold_data),
        .sop_i       (st_q.hold_sop),
        .eop_i       (st_q.hold_eop),
        .empty_i     (st_q.hold_empty),
        .seq_i       (seq),
        .crc_i       (st_q.crc),
        .main_o      (main_word),
        .main_last_o (main_last),
        .tail_o      (tail_word)
    );

    always_comb begin
        crc_base   = in_sop ? CRC_INIT : st_q.crc;
        crc_data   = in_data;
        if (in_sop) crc_data[WORD_W-1 -: SEQ_W] = '0;
        crc_nbytes = in_eop ? (CNT_W'(WORD_BYTES) - {1'b0, in_empty}) : CNT_W'(WORD_BYTES);
    end

    txf_crc_word #(.POLY(CRC_POLY)) crc_i (
        .crc_i    (crc_base),
        .data_i   (crc_data),
        .nbytes_i (crc_nbytes),
        .crc_o    (crc_next)
    );

    // output side: the spilled CRC word goes ahead of whatever is held
    always_comb begin
        out_valid = st_q.tail_vld | st_q.hold_vld;
        out_data  = st_q.tail_vld ? st_q.tail_data : main_word;
        out_sop   = !st_q.tail_vld && st_q.hold_sop;
        out_eop   = st_q.tail_vld || main_last;
        proto_err = st_q.err;
    end

    always_comb begin
        hold_fire = !st_q.tail_vld && st_q.hold_vld && out_ready;
        tail_fire = st_q.tail_vld && out_ready;
        in_ready  = st_q.tail_vld ? !st_q.hold_vld : (!st_q.hold_vld || out_ready);
        in_fire   = in_valid && in_ready;
        seq_adv   = out_valid && out_ready && out_eop;
    end

    always_comb begin
        st_d = st_q;
        if (hold_fire) begin
            st_d.hold_vld = 1'b0;
            if (st_q.hold_eop && !main_last) begin
                st_d.tail_vld  = 1'b1;
                st_d.tail_data = tail_word;
            end
        end
        if (tail_fire) st_d.tail_vld = 1'b0;
        if (in_fire) begin
            st_d.hold_vld   = 1'b1;
            st_d.hold_data  = in_data;
            st_d.hold_sop   = in_sop;
            st_d.hold_eop   = in_eop;
            st_d.hold_empty = in_eop ? in_empty : '0;
            st_d.crc        = crc_next;
            if (in_eop)      st_d.in_pkt = 1'b0;
            else if (in_sop) st_d.in_pkt = 1'b1;
        end
        st_d.err = st_q.in_pkt && !in_valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.crc <= CRC_INIT;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/txf_framer_chk.sv
module txf_framer_chk #(
    parameter int unsigned SEQ_W = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        in_sop,
    input logic        in_eop,
    input logic        out_valid,
    input logic        out_ready,
    input logic        out_sop,
    input logic        out_eop,
    input logic [31:0] out_data,
    input logic        proto_err
);
    logic [SEQ_W-1:0] exp_seq_q;
    logic             opkt_q, ipkt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_seq_q <= '0;
            opkt_q    <= 1'b0;
            ipkt_q    <= 1'b0;
        end else begin
            if (out_valid && out_ready) begin
                if (out_eop)      begin opkt_q <= 1'b0; exp_seq_q <= exp_seq_q + 1'b1; end
                else if (out_sop) opkt_q <= 1'b1;
            end
            if (in_valid && in_ready) begin
                if (in_eop)      ipkt_q <= 1'b0;
                else if (in_sop) ipkt_q <= 1'b1;
            end
        end
    end

    // R1
    held_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop));

    // R2
    seq_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sop |-> out_data[31 -: SEQ_W] == exp_seq_q);

    // R3
    start_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sop |-> !opkt_q);

    // R3
    body_framing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_sop |-> opkt_q);

    // R7
    gap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ipkt_q && !in_valid |=> proto_err);

    // R7
    quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ipkt_q && !in_valid) |=> !proto_err);
endmodule

bind txf_framer txf_framer_chk #(.SEQ_W(SEQ_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_data  (out_data),
    .proto_err (proto_err)
);

// File: tb/txf_framer_tb_top.sv
module txf_framer_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [1:0]  in_empty = '0;
    logic [31:0] in_data = '0;
    logic        out_ready = 1'b0;
    logic        in_ready, out_valid, out_sop, out_eop, proto_err;
    logic [31:0] out_data;

    int checks = 0, fails = 0, pkt_cnt = 0;
    logic [35:0] drv_q[$];
    logic [33:0] exp_q[$];
    string       tag_q[$];
    logic        ipkt = 1'b0, err_exp = 1'b0;
    logic        gap_mode = 1'b0, gap_done = 1'b0, rdy_full = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    txf_framer dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_sop(in_sop), .in_eop(in_eop),
        .in_empty(in_empty), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_sop(out_sop), .out_eop(out_eop),
        .out_data(out_data), .proto_err(proto_err)
    );

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ b[i]) r = {r[14:0], 1'b0} ^ 16'h1021;
            else              r = {r[14:0], 1'b0};
        end
        return r;
    endfunction

    // queue one packet and the words it must produce (R2 R3 R4 R5 R6)
    task automatic add_pkt(input int nb, input int emp);
        logic [7:0]  by[$];
        logic [31:0] w;
        logic [15:0] c;
        logic [5:0]  sq;
        int          len, nw, e, n;
        sq = 6'(pkt_cnt % 64);
        pkt_cnt++;
        for (int b = 0; b < nb; b++) begin
            w = $urandom;
            e = (b == nb - 1) ? emp : $urandom_range(0, 3);
            drv_q.push_back({b == 0, b == nb - 1, 2'(e), w});
            n = (b == nb - 1) ? 4 - emp : 4;
            for (int k = 0; k < n; k++) by.push_back(w[31-8*k -: 8]);
        end
        len = by.size();
        c = 16'hFFFF;
        for (int i = 0; i < len; i++) c = ref_crc(c, (i == 0) ? (by[i] & 8'h03) : by[i]);
        by[0] = {sq, by[0][1:0]};
        by.push_back(c[15:8]);
        by.push_back(c[7:0]);
        while (by.size() % 4 != 0) by.push_back(8'h00);
        nw = by.size() / 4;
        for (int j = 0; j < nw; j++) begin
            w = {by[4*j], by[4*j+1], by[4*j+2], by[4*j+3]};
            exp_q.push_back({j == 0, j == nw - 1, w});
            if (j == 0)              tag_q.push_back("R2/R3");
            else if (4*j + 4 > len)  tag_q.push_back("R4/R5");
            else                     tag_q.push_back("R3/R6");
        end
    endtask

    task automatic run_drain(input int limit);
        logic [33:0] ex;
        string       tg;
        int          cyc;
        logic        mid;
        cyc = 0;
        while (drv_q.size() > 0 || exp_q.size() > 0) begin
            @(negedge clk);
            cyc++;
            if (cyc > limit) begin
                fails++;
                $display("FAIL watchdog: actual %0d words pending, expected 0", exp_q.size());
                return;
            end
            in_valid = 1'b0;
            if (drv_q.size() > 0) begin
                mid = !drv_q[0][35];
                if (mid && gap_mode && !gap_done) begin
                    gap_done = 1'b1;
                end else if (mid || $urandom_range(0, 3) != 0) begin
                    in_valid = 1'b1;
                    {in_sop, in_eop, in_empty, in_data} = drv_q[0];
                end
            end
            out_ready = rdy_full ? 1'b1 : ($urandom_range(0, 3) != 0);
            #(CLK_PERIOD/4);
            // R7 proto_err one cycle after a gap inside a packet
            checks++;
            if (proto_err !== err_exp) begin
                fails++;
                $display("FAIL R7: proto_err actual %0b expected %0b", proto_err, err_exp);
            end
            err_exp = ipkt && !in_valid;
            // R1 input moves only with valid and ready
            if (in_valid && in_ready) begin
                if (in_eop)      ipkt = 1'b0;
                else if (in_sop) ipkt = 1'b1;
                void'(drv_q.pop_front());
            end
            if (out_valid && out_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    fails++;
                    $display("FAIL R3: actual extra word %h, expected none", out_data);
                end else begin
                    ex = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if ({out_sop, out_eop, out_data} !== ex) begin
                        fails++;
                        $display("FAIL %s: actual sop%0b eop%0b %h expected sop%0b eop%0b %h",
                                 tg, out_sop, out_eop, out_data, ex[33], ex[32], ex[31:0]);
                    end
                end
            end
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8 reset state
        checks++;
        if (out_valid !== 1'b0 || proto_err !== 1'b0 || in_ready !== 1'b1) begin
            fails++;
            $display("FAIL R8: actual valid%0b err%0b rdy%0b expected 0 0 1", out_valid, proto_err, in_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || proto_err !== 1'b0) begin
            fails++;
            $display("FAIL R8: after release actual valid%0b err%0b expected 0 0", out_valid, proto_err);
        end
        // directed: every trailing count, single-beat packets, back to back (R5 R6)
        rdy_full = 1'b1;
        for (int e = 0; e < 4; e++) add_pkt(1, e);
        add_pkt(2, 0); add_pkt(2, 2); add_pkt(3, 1); add_pkt(3, 3);
        run_drain(2000);
        // random stalls, past the sequence wrap (R1 R2)
        rdy_full = 1'b0;
        for (int p = 0; p < 150; p++) add_pkt($urandom_range(1, 6), $urandom_range(0, 3));
        run_drain(20000);
        // valid gap inside a packet (R7)
        gap_mode = 1'b1;
        add_pkt(4, 1);
        run_drain(2000);
        gap_mode = 1'b0;
        checks++;
        if (gap_done !== 1'b1) begin
            fails++;
            $display("FAIL R7: gap injected actual %0b expected 1", gap_done);
        end
        @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule